// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block is a general-purpose I/O port that sits on a simple 32-bit APB-style register bus. Each pin has an input path that is synchronised to the bus clock, an output data latch, an output enable and an alternate-function select bit. The alternate-function bit is only exported, because the pin multiplexer itself sits outside the block. Software changes the configuration bits through paired addresses: one address sets the bits written as 1 and the other clears them, so there is never a read-modify-write on a shared control word.

Each pin can raise an interrupt on a level or on an edge, with selectable polarity. Edge events are held in a per-pin status bit until software clears it by writing a 1 to that bit. Level events follow the pin. Per-pin interrupt lines and one combined OR line leave the block. A bank of read-only identification words sits near the top of the 4 KB register window.

Top module: `gpioPort`

## Requirements
- R1: After reset, the output latch, output enable, alternate function, interrupt enable, type, polarity and status registers all read 0, and the pin-enable and interrupt outputs are low.
- R2: Offset 0x000 returns the pin inputs after a two-flop synchroniser, so a change applied before two clock edges is visible. Offset 0x004 is the output latch and reads back the value last written.
- R3: `pinOut` carries the latch bit for each pin whose enable bit is 1 and is 0 otherwise. `pinOutEn` mirrors the enable register and `altSel` mirrors the alternate-function register.
- R4: Output enable is set through 0x010 and cleared through 0x014. Alternate function is set through 0x018 and cleared through 0x01C. A written 1 changes its bit, a written 0 leaves its bit alone, and both addresses of a pair read the current value.
- R5: Interrupt enable (set 0x020 / clear 0x024), type (set 0x028 / clear 0x02C) and polarity (set 0x030 / clear 0x034) follow the same set/clear and readback rules.
- R6: A type bit of 1 selects edge mode. A polarity of 1 selects the rising edge and 0 the falling edge. The status bit rises on the third clock edge after the pin changes and stays set after the pin returns.
- R7: A type bit of 0 selects level mode. A polarity of 1 selects high and 0 selects low. The status follows the qualified level, so a clear write while the level persists leaves it set, and it drops once the level goes away.
- R8: Reading 0x038 returns the status bits. Writing 0x038 clears each bit written as 1. When a clear and a new event land on the same edge, the event wins.
- R9: A status bit is set only while its interrupt enable is 1, and clearing the enable drops it. `irqPin` is the per-pin status and `irqAny` is the OR of all pins.
- R10: Identification words read at 0xFD0, 0xFD4, 0xFD8, 0xFDC, 0xFE0, 0xFE4, 0xFE8, 0xFEC and 0xFF0 with the values 0x04, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05 and 0xB1.
- R11: Reserved or unaligned offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and port clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, decoded from paddr |
| pinIn | input | PINS | Asynchronous pin inputs |
| pinOut | output | PINS | Output values gated by the enables |
| pinOutEn | output | PINS | Per-pin output enable |
| altSel | output | PINS | Per-pin alternate-function select |
| irqPin | output | PINS | Per-pin interrupt |
| irqAny | output | 1 | OR of all pin interrupts |

## Verification
Register patterns such as alternating bits, partial masks and all-zero writes go to each set/clear pair. These show whether a 0 bit really leaves its neighbour alone and whether both addresses read the same value. Rising, falling, high and low pin stimuli are applied with the pin's enable on and off. An exact cycle check on the edge path catches a missing or extra synchroniser stage. A clear write that lands on the same edge as a fresh edge event shows which of the two takes priority, and a clear write under a persistent level shows the difference between level and latched behaviour.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [3:0] {
    RD_ZERO, RD_DIN, RD_DOUT, RD_OE, RD_ALT, RD_IE, RD_TYPE, RD_POL, RD_STAT, RD_ID
  } rdSel_e;

  typedef struct packed {
    logic   wrDout;
    logic   setOe;
    logic   clrOe;
    logic   setAlt;
    logic   clrAlt;
    logic   setIe;
    logic   clrIe;
    logic   setType;
    logic   clrType;
    logic   setPol;
    logic   clrPol;
    logic   clrStat;
    rdSel_e rdSel;
    logic [3:0] idIdx;
  } ctrlStrobe_t;

  localparam logic [9:0] ID_BASE_WORD = 10'h3F4;
  localparam int         ID_COUNT     = 9;

  function automatic logic [7:0] idByte(input logic [3:0] idx);
    case (idx)
      4'd0:    return 8'h04;
      4'd1:    return 8'h54;
      4'd2:    return 8'hB8;
      4'd3:    return 8'h0B;
      4'd4:    return 8'h00;
      4'd5:    return 8'h0D;
      4'd6:    return 8'hF0;
      4'd7:    return 8'h05;
      4'd8:    return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/gpioCtrl.sv
module gpioCtrl
  import gpio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  output ctrlStrobe_t strobe
);

  logic [9:0] wordIdx;
  logic       aligned;
  logic       wrFire;
  logic [9:0] idOff;

  assign wordIdx = paddr[11:2];
  assign aligned = (paddr[1:0] == 2'b00);
  assign wrFire  = psel && penable && pwrite && aligned;
  assign idOff   = wordIdx - ID_BASE_WORD;

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_ZERO;
    if (aligned) begin
      case (wordIdx)
        10'h000: strobe.rdSel = RD_DIN;
        10'h001: begin strobe.rdSel = RD_DOUT; strobe.wrDout  = wrFire; end
        10'h004: begin strobe.rdSel = RD_OE;   strobe.setOe   = wrFire; end
        10'h005: begin strobe.rdSel = RD_OE;   strobe.clrOe   = wrFire; end
        10'h006: begin strobe.rdSel = RD_ALT;  strobe.setAlt  = wrFire; end
        10'h007: begin strobe.rdSel = RD_ALT;  strobe.clrAlt  = wrFire; end
        10'h008: begin strobe.rdSel = RD_IE;   strobe.setIe   = wrFire; end
        10'h009: begin strobe.rdSel = RD_IE;   strobe.clrIe   = wrFire; end
        10'h00A: begin strobe.rdSel = RD_TYPE; strobe.setType = wrFire; end
        10'h00B: begin strobe.rdSel = RD_TYPE; strobe.clrType = wrFire; end
        10'h00C: begin strobe.rdSel = RD_POL;  strobe.setPol  = wrFire; end
        10'h00D: begin strobe.rdSel = RD_POL;  strobe.clrPol  = wrFire; end
        10'h00E: begin strobe.rdSel = RD_STAT; strobe.clrStat = wrFire; end
        default: begin
          if (wordIdx >= ID_BASE_WORD && idOff < 10'(ID_COUNT)) begin
            strobe.rdSel = RD_ID;
            strobe.idIdx = idOff[3:0];
          end
        end
      endcase
    end
  end

  // R11: at most one register action per access, none for reserved offsets
  p_one_action_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrDout, strobe.setOe, strobe.clrOe, strobe.setAlt, strobe.clrAlt,
              strobe.setIe, strobe.clrIe, strobe.setType, strobe.clrType,
              strobe.setPol, strobe.clrPol, strobe.clrStat}));

  p_no_write_on_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    !pwrite |-> !(strobe.wrDout || strobe.setOe || strobe.setIe || strobe.clrStat));

endmodule

// File: rtl/gpioDatapath.sv
module gpioDatapath
  import gpio_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic [PINS-1:0] wdata,
  input  logic [PINS-1:0] pinIn,
  output logic [31:0]     rdata,
  output logic [PINS-1:0] pinOut,
  output logic [PINS-1:0] pinOutEn,
  output logic [PINS-1:0] altSel,
  output logic [PINS-1:0] irqPin,
  output logic            irqAny
);

  logic [PINS-1:0] syncA, syncB, prevS;
  logic [PINS-1:0] doutR, oeR, altR, ieR, typeR, polR, statusR;
  logic [PINS-1:0] edgeHit, levelHit, clrMask, statusNext;

  function automatic logic [PINS-1:0] setClr(input logic [PINS-1:0] cur,
                                             input logic s, input logic c,
                                             input logic [PINS-1:0] d);
    logic [PINS-1:0] r;
    r = cur;
    if (s) r = r | d;
    if (c) r = r & ~d;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0; syncB <= '0; prevS <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevS <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doutR <= '0; oeR <= '0; altR <= '0;
      ieR <= '0; typeR <= '0; polR <= '0;
    end else begin
      if (strobe.wrDout) doutR <= wdata;
      oeR   <= setClr(oeR,   strobe.setOe,   strobe.clrOe,   wdata);
      altR  <= setClr(altR,  strobe.setAlt,  strobe.clrAlt,  wdata);
      ieR   <= setClr(ieR,   strobe.setIe,   strobe.clrIe,   wdata);
      typeR <= setClr(typeR, strobe.setType, strobe.clrType, wdata);
      polR  <= setClr(polR,  strobe.setPol,  strobe.clrPol,  wdata);
    end
  end

  // per-pin detection; events override a same-cycle clear
  genvar gi;
  generate
    for (gi = 0; gi < PINS; gi++) begin : g_pin
      assign edgeHit[gi]  = typeR[gi] &&
                            (polR[gi] ? (syncB[gi] && !prevS[gi]) : (!syncB[gi] && prevS[gi]));
      assign levelHit[gi] = !typeR[gi] && (polR[gi] == syncB[gi]);
      assign statusNext[gi] = ieR[gi] &&
                              (edgeHit[gi] || levelHit[gi] ||
                               (typeR[gi] && statusR[gi] && !clrMask[gi]));
    end
  endgenerate

  assign clrMask = strobe.clrStat ? wdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusR <= '0;
    else       statusR <= statusNext;
  end

  assign pinOutEn = oeR;
  assign pinOut   = doutR & oeR;
  assign altSel   = altR;
  assign irqPin   = statusR & ieR;
  assign irqAny   = |irqPin;

  always_comb begin
    rdata = '0;
    case (strobe.rdSel)
      RD_DIN:  rdata[PINS-1:0] = syncB;
      RD_DOUT: rdata[PINS-1:0] = doutR;
      RD_OE:   rdata[PINS-1:0] = oeR;
      RD_ALT:  rdata[PINS-1:0] = altR;
      RD_IE:   rdata[PINS-1:0] = ieR;
      RD_TYPE: rdata[PINS-1:0] = typeR;
      RD_POL:  rdata[PINS-1:0] = polR;
      RD_STAT: rdata[PINS-1:0] = statusR;
      RD_ID:   rdata[7:0]      = idByte(strobe.idIdx);
      default: rdata = '0;
    endcase
  end

  p_dout_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDout |=> (doutR == $past(wdata)));

  p_oe_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setOe |=> ((oeR & $past(wdata)) == $past(wdata)));

  p_ie_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrIe |=> ((ieR & $past(wdata)) == '0));

  p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrStat |=> ((($past(statusR & typeR & ieR) & typeR & ieR) & ~statusR) == '0));

  p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqAny |-> (ieR != '0));

endmodule

// File: rtl/gpioPort.sv
module gpioPort
  import gpio_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [11:0]     paddr,
  input  logic [31:0]     pwdata,
  output logic [31:0]     prdata,
  input  logic [PINS-1:0] pinIn,
  output logic [PINS-1:0] pinOut,
  output logic [PINS-1:0] pinOutEn,
  output logic [PINS-1:0] altSel,
  output logic [PINS-1:0] irqPin,
  output logic            irqAny
);

  ctrlStrobe_t strobe;

  gpioCtrl uCtrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .strobe(strobe)
  );

  gpioDatapath #(.PINS(PINS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(pwdata[PINS-1:0]),
    .pinIn(pinIn), .rdata(prdata), .pinOut(pinOut), .pinOutEn(pinOutEn),
    .altSel(altSel), .irqPin(irqPin), .irqAny(irqAny)
  );

endmodule

// File: tb/tb_gpioPort.sv
`timescale 1ns/1ps
module tb_gpioPort;

  localparam int PINS = 16;

  logic            clk = 0;
  logic            rstN = 0;
  logic            psel = 0, penable = 0, pwrite = 0;
  logic [11:0]     paddr = '0;
  logic [31:0]     pwdata = '0;
  logic [31:0]     prdata;
  logic [PINS-1:0] pinIn = '0;
  logic [PINS-1:0] pinOut, pinOutEn, altSel, irqPin;
  logic            irqAny;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  gpioPort #(.PINS(PINS)) dut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOutEn(pinOutEn), .altSel(altSel),
    .irqPin(irqPin), .irqAny(irqAny)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h004, 32'h0000A5A5, 32'h0, 8'd2},
    '{1'b0, 12'h004, 32'h0, 32'h0000A5A5, 8'd2},   // R2 latch readback
    '{1'b1, 12'h010, 32'h000000FF, 32'h0, 8'd4},
    '{1'b0, 12'h010, 32'h0, 32'h000000FF, 8'd4},   // R4 set
    '{1'b1, 12'h014, 32'h0000000F, 32'h0, 8'd4},
    '{1'b0, 12'h014, 32'h0, 32'h000000F0, 8'd4},   // R4 clear, both addresses read
    '{1'b1, 12'h018, 32'h00001200, 32'h0, 8'd4},
    '{1'b1, 12'h01C, 32'h00000200, 32'h0, 8'd4},
    '{1'b0, 12'h018, 32'h0, 32'h00001000, 8'd4},   // R4 alt pair
    '{1'b1, 12'h028, 32'h0000F000, 32'h0, 8'd5},
    '{1'b1, 12'h02C, 32'h00003000, 32'h0, 8'd5},
    '{1'b0, 12'h028, 32'h0, 32'h0000C000, 8'd5},   // R5 type pair
    '{1'b1, 12'h030, 32'h000000FF, 32'h0, 8'd5},
    '{1'b1, 12'h034, 32'h00000000, 32'h0, 8'd5},
    '{1'b0, 12'h034, 32'h0, 32'h000000FF, 8'd5},   // R5 zero clear leaves bits
    '{1'b0, 12'hFD0, 32'h0, 32'h00000004, 8'd10},  // R10 first id word
    '{1'b0, 12'hFD4, 32'h0, 32'h00000054, 8'd10},
    '{1'b0, 12'hFEC, 32'h0, 32'h00000005, 8'd10},
    '{1'b0, 12'hFF0, 32'h0, 32'h000000B1, 8'd10},  // R10 last id word
    '{1'b0, 12'h008, 32'h0, 32'h00000000, 8'd11}   // R11 reserved reads 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    waitCyc(3);
    rstN = 1;
    waitCyc(2);

    // R1: reset values
    busRead(12'h004, rd); check("R1 dout", rd, 0);
    busRead(12'h010, rd); check("R1 oe", rd, 0);
    busRead(12'h018, rd); check("R1 alt", rd, 0);
    busRead(12'h020, rd); check("R1 ie", rd, 0);
    busRead(12'h028, rd); check("R1 type", rd, 0);
    busRead(12'h030, rd); check("R1 pol", rd, 0);
    busRead(12'h038, rd); check("R1 status", rd, 0);
    check("R1 outputs", {15'd0, irqAny, pinOutEn}, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) busWrite(VECS[i].addr, VECS[i].data);
      else begin
        busRead(VECS[i].addr, rd);
        check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
      end
    end

    // R3: pins follow latch and enables
    check("R3 pinOut", 32'(pinOut), 32'h000000A0);
    check("R3 pinOutEn", 32'(pinOutEn), 32'h000000F0);
    check("R3 altSel", 32'(altSel), 32'h00001000);

    // R11: reserved and unaligned writes ignored
    busWrite(12'h040, 32'hFFFF);
    busWrite(12'h005, 32'hFFFF);
    busWrite(12'hFCC, 32'hFFFF);
    busRead(12'h004, rd); check("R11 dout kept", rd, 32'hA5A5);
    busRead(12'h010, rd); check("R11 oe kept", rd, 32'h00F0);
    busRead(12'h020, rd); check("R11 ie kept", rd, 0);
    busRead(12'h006, rd); check("R11 unaligned read", rd, 0);

    // R2: synchronised input
    @(negedge clk); pinIn = 16'h1234;
    busRead(12'h000, rd); check("R2 din", rd, 32'h1234);

    // clean interrupt config
    pinIn = '0;
    busWrite(12'h02C, 32'hFFFF);
    busWrite(12'h034, 32'hFFFF);
    waitCyc(4);

    // R6: rising edge on pin0, exact latency
    busWrite(12'h028, 32'h1);
    busWrite(12'h030, 32'h1);
    busWrite(12'h020, 32'h1);
    @(negedge clk); pinIn[0] = 1;
    waitCyc(2); check("R6 not before third edge", 32'(irqPin[0]), 0);
    waitCyc(1); check("R6 third edge", 32'(irqPin[0]), 1);
    pinIn[0] = 0; waitCyc(5);
    check("R6 latched", 32'(irqPin[0]), 1);
    busRead(12'h038, rd); check("R8 status read", rd, 32'h1);

    // R8: clear and new edge on the same edge, event wins
    waitCyc(4);
    @(negedge clk); pinIn[0] = 1;
    busWrite(12'h038, 32'h1);
    busRead(12'h038, rd); check("R8 event beats clear", rd, 32'h1);
    busWrite(12'h038, 32'h1);
    busRead(12'h038, rd); check("R8 clear", rd, 0);

    // R6: falling edge on pin1
    @(negedge clk); pinIn[1] = 1;
    busWrite(12'h028, 32'h2);
    busWrite(12'h020, 32'h2);
    waitCyc(4);
    check("R6 no rise for falling pol", 32'(irqPin[1]), 0);
    pinIn[1] = 0; waitCyc(3);
    check("R6 falling", 32'(irqPin[1]), 1);
    check("R9 irqAny", 32'(irqAny), 1);
    busWrite(12'h038, 32'h2);

    // R7: level high on pin2
    busWrite(12'h030, 32'h4);
    busWrite(12'h020, 32'h4);
    waitCyc(2);
    check("R7 level idle", 32'(irqPin[2]), 0);
    @(negedge clk); pinIn[2] = 1; waitCyc(4);
    check("R7 level high", 32'(irqPin[2]), 1);
    busWrite(12'h038, 32'h4);
    busRead(12'h038, rd); check("R7 clear ignored while high", rd & 32'h4, 32'h4);
    @(negedge clk); pinIn[2] = 0; waitCyc(4);
    check("R7 level gone", 32'(irqPin[2]), 0);

    // R7: level low on pin3 (pol 0, type 0)
    busWrite(12'h020, 32'h8);
    waitCyc(1);
    check("R7 low level", 32'(irqPin[3]), 1);
    busWrite(12'h024, 32'h8);
    check("R9 disable drops", 32'(irqPin[3]), 0);

    // R9: disabled edge pin never latches
    busWrite(12'h028, 32'h10);
    busWrite(12'h030, 32'h10);
    @(negedge clk); pinIn[4] = 1; waitCyc(5);
    busRead(12'h038, rd); check("R9 no status when disabled", rd & 32'h10, 0);
    busWrite(12'h020, 32'h10);
    waitCyc(3);
    check("R9 enable later no stale", 32'(irqPin[4]), 0);
    check("R9 irqAny idle", 32'(irqAny), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule